// File: doc/BRIEF.md
# Synchronous Serial Frame Engine

A full-duplex serial engine that moves 24-bit words between a parallel register interface and a bit-serial line, one bit per bit-clock enable. A transmit holding register feeds a transmit shift register. A receive shift register fills a receive holding register. Each side has a one-bit status flag, transmit-empty and receive-full, so that a controller can pace the traffic.

A frame is a programmable number of word slots. In normal mode only the first slot of each frame carries data. In network mode every slot carries a word. The bit clock is supplied as a one-cycle enable on the system clock. The frame sync is either generated inside the block or taken from an input. Transmit and receive can share one timing source, or the receiver can run from its own bit enable and its own frame sync. The word length is programmable. The shift direction is programmable. The length of each generated frame-sync pulse can be set to one bit or one word, separately for each direction.

Top module: `ssfe_engine`

## Requirements
- R1: After reset, tx_empty is 1, and rx_full, tx_underrun, rx_overrun, sdo, fs_tx_out and fs_rx_out are all 0.
- R2: cfg_word_len selects 8 (00), 12 (01), 16 (10) or 24 (11) bits per word. Words are left-justified in the 24-bit registers: only the top bits are sent, and a received word has zeros below its lowest bit.
- R3: With cfg_lsb_first=0, bit 23 goes out first and the bits descend. With cfg_lsb_first=1, bit 24-N goes out first and the bits ascend. The receiver places incoming bits in the same order.
- R4: In normal mode (cfg_network=0), only slot 0 of a frame transfers data. In the other slots sdo is 0, the transmit holding register is not consumed and nothing is received.
- R5: In network mode (cfg_network=1), every slot of the frame loads a transmit word and delivers a received word.
- R6: A frame holds cfg_frame_words+1 slots. A value of 0 gives one slot per frame, so every word starts a frame.
- R7: The generated receive frame sync lasts the whole first slot when cfg_rx_fs_bit=0, and only its first bit when cfg_rx_fs_bit=1.
- R8: The generated transmit frame sync has the receive length when cfg_fs_differ=0 and the opposite length when cfg_fs_differ=1.
- R9: With cfg_sync=1, the receiver runs from tx_tick and the transmit frame. With cfg_sync=0, it runs only from rx_tick and its own frame.
- R10: With internal sync, a frame starts on the first bit enable after enable. With external sync, a frame starts on the bit enable at which the frame-sync input is first seen high, and nothing is received before that.
- R11: If the holding register is empty when a transfer slot starts, the previous shift data is sent again and tx_underrun is set. tx_wr clears tx_underrun.
- R12: If a word completes while rx_full is still set, rx_rdata is overwritten and rx_overrun is set. rx_rd clears rx_overrun.
- R13: tx_wr clears tx_empty. Loading the shift register at a slot start sets tx_empty. rx_rd clears rx_full.
- R14: With tx_en and rx_en both 0, the timing stops, both frame-sync outputs and sdo stay 0, and a written word is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_network | input | 1 | 0 normal, 1 network |
| cfg_sync | input | 1 | Receiver shares transmit timing |
| cfg_fs_internal | input | 1 | Generate frame sync internally |
| cfg_lsb_first | input | 1 | Shift direction |
| cfg_rx_fs_bit | input | 1 | Receive sync: 0 word-long, 1 bit-long |
| cfg_fs_differ | input | 1 | Transmit sync length differs from receive |
| cfg_word_len | input | 2 | Word length code |
| cfg_frame_words | input | SLOT_W | Slots per frame minus one |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_tick | input | 1 | Transmit bit-clock enable |
| rx_tick | input | 1 | Receive bit-clock enable |
| fs_tx_in | input | 1 | External transmit frame sync |
| fs_rx_in | input | 1 | External receive frame sync |
| fs_tx_out | output | 1 | Generated transmit frame sync |
| fs_rx_out | output | 1 | Generated receive frame sync |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| tx_wr | input | 1 | Write transmit holding register |
| tx_wdata | input | DATA_W | Transmit word |
| tx_empty | output | 1 | Transmit holding register empty |
| tx_underrun | output | 1 | Transmit underrun flag |
| rx_rd | input | 1 | Acknowledge received word |
| rx_rdata | output | DATA_W | Received word |
| rx_full | output | 1 | Receive holding register full |
| rx_overrun | output | 1 | Receive overrun flag |

## Verification
The hardest state to reach is a network frame in which a transmit underrun and a receive overrun fall on the same bit enable. This needs an empty holding register at a slot start while an unread word is still in the receive register. The bench reaches it with sdo looped back to sdi and two slots per frame. It writes only the first two words and never reads, so the third slot start re-sends the second word and overwrites the receive register. The serial bits of that slot are captured and compared against the repeated word.

// File: rtl/ssfe_pkg.sv
package ssfe_pkg;

   typedef logic [4:0] bitcnt_t;

   typedef enum logic {
      FS_WORD = 1'b0,
      FS_BIT  = 1'b1
   } fs_len_e;

   function automatic bitcnt_t wl_last(input logic [1:0] code);
      case (code)
         2'b00:   return 5'd7;
         2'b01:   return 5'd11;
         2'b10:   return 5'd15;
         default: return 5'd23;
      endcase
   endfunction

   function automatic int wl_len(input logic [1:0] code);
      return int'(wl_last(code)) + 1;
   endfunction

   // register bit that carries serial bit number idx of a left-justified word
   function automatic int bit_pos(input int data_w, input logic [1:0] code,
                                  input logic lsb, input bitcnt_t idx);
      return lsb ? (data_w - wl_len(code) + int'(idx)) : (data_w - 1 - int'(idx));
   endfunction

endpackage

// File: rtl/ssfe_slot_timer.sv
module ssfe_slot_timer
   import ssfe_pkg::*;
#(
   parameter int SLOT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              fs_internal,
   input  logic              fs_in,
   input  fs_len_e           fs_len,
   input  bitcnt_t           last_bit,
   input  logic [SLOT_W-1:0] last_word,
   output logic              running,
   output bitcnt_t           bit_idx,
   output logic [SLOT_W-1:0] word_idx,
   output logic              slot_load,
   output logic [SLOT_W-1:0] load_word,
   output logic              sample,
   output logic              fs_out
);

   logic fs_prev;
   logic start;
   logic adv;

   always_comb begin
      start     = en && tick && (fs_internal ? !running : (fs_in && !fs_prev));
      adv       = en && tick && running && !start;
      slot_load = start || (adv && (bit_idx >= last_bit));
      sample    = en && tick && running;
      if (start || word_idx >= last_word) load_word = '0;
      else                                load_word = word_idx + SLOT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running  <= 1'b0;
         bit_idx  <= '0;
         word_idx <= '0;
         fs_prev  <= 1'b0;
      end else if (!en) begin
         running  <= 1'b0;
         bit_idx  <= '0;
         word_idx <= '0;
         fs_prev  <= 1'b0;
      end else if (tick) begin
         fs_prev <= fs_in;
         if (slot_load) begin
            running  <= 1'b1;
            bit_idx  <= '0;
            word_idx <= load_word;
         end else if (adv) begin
            bit_idx <= bit_idx + 5'd1;
         end
      end
   end

   assign fs_out = running && fs_internal && (word_idx == '0) &&
                   ((fs_len == FS_WORD) || (bit_idx == '0));

endmodule

// File: rtl/ssfe_tx.sv
module ssfe_tx
   import ssfe_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int SLOT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              slot_load,
   input  logic [SLOT_W-1:0] load_word,
   input  logic              running,
   input  bitcnt_t           bit_idx,
   input  logic [SLOT_W-1:0] word_idx,
   input  logic              network,
   input  logic              lsb_first,
   input  logic [1:0]        word_code,
   output logic              sdo,
   output logic              empty,
   output logic              underrun
);

   localparam int IDX_W = $clog2(DATA_W);

   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] shift_q;
   logic [IDX_W-1:0]  pos;
   logic              take;
   logic              active;

   assign take   = en && slot_load && (network || load_word == '0);
   assign active = en && running && (network || word_idx == '0);
   assign pos    = IDX_W'(bit_pos(DATA_W, word_code, lsb_first, bit_idx));
   assign sdo    = active && shift_q[pos];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q   <= '0;
         shift_q  <= '0;
         empty    <= 1'b1;
         underrun <= 1'b0;
      end else begin
         if (take) begin
            if (!empty) begin
               shift_q <= hold_q;
               empty   <= 1'b1;
            end else begin
               underrun <= 1'b1;
            end
         end
         if (wr) begin
            hold_q   <= wdata;
            empty    <= 1'b0;
            underrun <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ssfe_rx.sv
module ssfe_rx
   import ssfe_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int SLOT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              rd,
   input  logic              sdi,
   input  logic              slot_load,
   input  logic [SLOT_W-1:0] load_word,
   input  logic              sample,
   input  logic              running,
   input  bitcnt_t           bit_idx,
   input  logic [SLOT_W-1:0] word_idx,
   input  logic              network,
   input  logic              lsb_first,
   input  logic [1:0]        word_code,
   output logic [DATA_W-1:0] rdata,
   output logic              full,
   output logic              overrun,
   output logic              done
);

   localparam int IDX_W = $clog2(DATA_W);

   logic [DATA_W-1:0] shift_q;
   logic [DATA_W-1:0] word_v;
   logic [IDX_W-1:0]  pos;
   logic              cap;

   assign pos  = IDX_W'(bit_pos(DATA_W, word_code, lsb_first, bit_idx));
   assign cap  = en && sample && running && (network || word_idx == '0);
   assign done = cap && (bit_idx >= wl_last(word_code));

   always_comb begin
      word_v      = shift_q;
      word_v[pos] = sdi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         rdata   <= '0;
         full    <= 1'b0;
         overrun <= 1'b0;
      end else begin
         if (cap) shift_q <= word_v;
         if (en && slot_load && (network || load_word == '0)) shift_q <= '0;
         if (rd) begin
            full    <= 1'b0;
            overrun <= 1'b0;
         end
         if (done) begin
            rdata <= word_v;
            full  <= 1'b1;
            if (full && !rd) overrun <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ssfe_engine.sv
module ssfe_engine
   import ssfe_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int SLOT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_network,
   input  logic              cfg_sync,
   input  logic              cfg_fs_internal,
   input  logic              cfg_lsb_first,
   input  logic              cfg_rx_fs_bit,
   input  logic              cfg_fs_differ,
   input  logic [1:0]        cfg_word_len,
   input  logic [SLOT_W-1:0] cfg_frame_words,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              tx_tick,
   input  logic              rx_tick,
   input  logic              fs_tx_in,
   input  logic              fs_rx_in,
   output logic              fs_tx_out,
   output logic              fs_rx_out,
   output logic              sdo,
   input  logic              sdi,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_wdata,
   output logic              tx_empty,
   output logic              tx_underrun,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_rdata,
   output logic              rx_full,
   output logic              rx_overrun
);

   localparam int NCH = 2;  // channel 0 drives transmit, channel 1 serves an independent receiver

   if (DATA_W < 24) begin : g_bad_width
      $error("ssfe_engine: DATA_W must hold a 24-bit word");
   end
   if (SLOT_W < 1 || SLOT_W > 8) begin : g_bad_slots
      $error("ssfe_engine: SLOT_W out of range");
   end

   logic [NCH-1:0]    ch_en, ch_tick, ch_fs_in;
   fs_len_e           ch_len   [NCH];
   logic [NCH-1:0]    ch_run, ch_load, ch_sample, ch_fs;
   bitcnt_t           ch_bit   [NCH];
   logic [SLOT_W-1:0] ch_word  [NCH];
   logic [SLOT_W-1:0] ch_lword [NCH];
   logic              rsel;
   logic              rx_done;

   assign rsel        = !cfg_sync;
   assign ch_en[0]    = tx_en || (cfg_sync && rx_en);
   assign ch_en[1]    = rx_en && !cfg_sync;
   assign ch_tick     = {rx_tick, tx_tick};
   assign ch_fs_in    = {fs_rx_in, fs_tx_in};

   always_comb begin
      ch_len[1] = cfg_rx_fs_bit ? FS_BIT : FS_WORD;
      ch_len[0] = (cfg_rx_fs_bit ^ cfg_fs_differ) ? FS_BIT : FS_WORD;
   end

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      ssfe_slot_timer #(.SLOT_W(SLOT_W)) u_timer (
         .clk         (clk),
         .rst_n       (rst_n),
         .en          (ch_en[g]),
         .tick        (ch_tick[g]),
         .fs_internal (cfg_fs_internal),
         .fs_in       (ch_fs_in[g]),
         .fs_len      (ch_len[g]),
         .last_bit    (wl_last(cfg_word_len)),
         .last_word   (cfg_frame_words),
         .running     (ch_run[g]),
         .bit_idx     (ch_bit[g]),
         .word_idx    (ch_word[g]),
         .slot_load   (ch_load[g]),
         .load_word   (ch_lword[g]),
         .sample      (ch_sample[g]),
         .fs_out      (ch_fs[g])
      );
   end

   assign fs_tx_out = ch_fs[0];
   assign fs_rx_out = ch_fs[rsel];

   ssfe_tx #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (tx_en),
      .wr        (tx_wr),
      .wdata     (tx_wdata),
      .slot_load (ch_load[0]),
      .load_word (ch_lword[0]),
      .running   (ch_run[0]),
      .bit_idx   (ch_bit[0]),
      .word_idx  (ch_word[0]),
      .network   (cfg_network),
      .lsb_first (cfg_lsb_first),
      .word_code (cfg_word_len),
      .sdo       (sdo),
      .empty     (tx_empty),
      .underrun  (tx_underrun)
   );

   ssfe_rx #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (rx_en),
      .rd        (rx_rd),
      .sdi       (sdi),
      .slot_load (ch_load[rsel]),
      .load_word (ch_lword[rsel]),
      .sample    (ch_sample[rsel]),
      .running   (ch_run[rsel]),
      .bit_idx   (ch_bit[rsel]),
      .word_idx  (ch_word[rsel]),
      .network   (cfg_network),
      .lsb_first (cfg_lsb_first),
      .word_code (cfg_word_len),
      .rdata     (rx_rdata),
      .full      (rx_full),
      .overrun   (rx_overrun),
      .done      (rx_done)
   );

endmodule

// File: rtl/ssfe_engine_chk.sv
module ssfe_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic rx_en,
   input logic tx_wr,
   input logic rx_rd,
   input logic rx_done,
   input logic tx_empty,
   input logic tx_underrun,
   input logic rx_full,
   input logic rx_overrun,
   input logic sdo,
   input logic fs_tx_out,
   input logic fs_rx_out
);

   AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr |=> !tx_empty);  // R13

   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && !rx_done) |=> !rx_full);  // R13

   AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_underrun) |-> $past(tx_empty));  // R11

   AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_overrun) |-> ($past(rx_full) && $past(rx_done)));  // R12

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !rx_en) |=> (!fs_tx_out && !fs_rx_out && !sdo));  // R14

endmodule

bind ssfe_engine ssfe_engine_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_en       (tx_en),
   .rx_en       (rx_en),
   .tx_wr       (tx_wr),
   .rx_rd       (rx_rd),
   .rx_done     (rx_done),
   .tx_empty    (tx_empty),
   .tx_underrun (tx_underrun),
   .rx_full     (rx_full),
   .rx_overrun  (rx_overrun),
   .sdo         (sdo),
   .fs_tx_out   (fs_tx_out),
   .fs_rx_out   (fs_rx_out)
);

// File: tb/tb_ssfe_engine.sv
module tb_ssfe_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_network = 0, cfg_sync = 1, cfg_fs_internal = 1, cfg_lsb_first = 0;
   logic        cfg_rx_fs_bit = 0, cfg_fs_differ = 0;
   logic [1:0]  cfg_word_len = 2'b00;
   logic [4:0]  cfg_frame_words = '0;
   logic        tx_en = 0, rx_en = 0, tx_tick = 0, rx_tick = 0;
   logic        fs_tx_in = 0, fs_rx_in = 0;
   logic        fs_tx_out, fs_rx_out, sdo, sdi;
   logic        tx_wr = 0, rx_rd = 0;
   logic [23:0] tx_wdata = '0;
   logic        tx_empty, tx_underrun, rx_full, rx_overrun;
   logic [23:0] rx_rdata;
   logic        loop = 1'b1, sdi_drv = 1'b0;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;
   assign sdi = loop ? sdo : sdi_drv;

   ssfe_engine dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_network(cfg_network), .cfg_sync(cfg_sync), .cfg_fs_internal(cfg_fs_internal),
      .cfg_lsb_first(cfg_lsb_first), .cfg_rx_fs_bit(cfg_rx_fs_bit), .cfg_fs_differ(cfg_fs_differ),
      .cfg_word_len(cfg_word_len), .cfg_frame_words(cfg_frame_words),
      .tx_en(tx_en), .rx_en(rx_en), .tx_tick(tx_tick), .rx_tick(rx_tick),
      .fs_tx_in(fs_tx_in), .fs_rx_in(fs_rx_in), .fs_tx_out(fs_tx_out), .fs_rx_out(fs_rx_out),
      .sdo(sdo), .sdi(sdi), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_empty(tx_empty),
      .tx_underrun(tx_underrun), .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_full(rx_full),
      .rx_overrun(rx_overrun)
   );

   // {word_len code, lsb_first, data}
   localparam logic [26:0] VEC [7] = '{
      {2'b00, 1'b0, 24'hA5C3F1},
      {2'b00, 1'b1, 24'hA5C3F1},
      {2'b01, 1'b0, 24'h123456},
      {2'b01, 1'b1, 24'h9ABCDE},
      {2'b10, 1'b1, 24'hC0FFEE},
      {2'b11, 1'b0, 24'h5A5A3C},
      {2'b11, 1'b1, 24'h8E7D21}
   };

   function automatic int wl_n(input logic [1:0] c);
      case (c)
         2'b00:   return 8;
         2'b01:   return 12;
         2'b10:   return 16;
         default: return 24;
      endcase
   endfunction

   function automatic logic [23:0] exp_stream(input logic [23:0] d, input int n, input bit lsb);
      logic [23:0] s;
      s = '0;
      for (int i = 0; i < n; i++) s[i] = lsb ? d[24 - n + i] : d[23 - i];
      return s;
   endfunction

   function automatic logic [23:0] exp_word(input logic [23:0] d, input int n);
      return d & (24'hFFFFFF << (24 - n));
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tk(input bit t, input bit r);
      @(negedge clk);
      tx_tick = t;
      rx_tick = r;
      @(negedge clk);
      tx_tick = 0;
      rx_tick = 0;
   endtask

   task automatic wr(input logic [23:0] d);
      @(negedge clk);
      tx_wr = 1;
      tx_wdata = d;
      @(negedge clk);
      tx_wr = 0;
   endtask

   task automatic rd();
      @(negedge clk);
      rx_rd = 1;
      @(negedge clk);
      rx_rd = 0;
   endtask

   task automatic run_bits(input int n, output logic [23:0] s);
      s = '0;
      for (int i = 0; i < n; i++) begin
         tk(1, 0);
         s[i] = sdo;
      end
   endtask

   task automatic stop_all();
      tx_en = 0;
      rx_en = 0;
      tk(0, 0);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [23:0] s;
      logic [1:0]  wl;
      logic        lb;
      logic [23:0] d;
      int          n, cnt_tx, cnt_rx;
      bit          quiet;

      repeat (3) @(negedge clk);
      // R1: reset state
      check(tx_empty && !rx_full && !tx_underrun && !rx_overrun && !sdo && !fs_tx_out && !fs_rx_out,
            "R1 reset flags", {26'd0, tx_empty, rx_full, tx_underrun, rx_overrun, sdo, fs_tx_out}, 32'h20);
      rst_n = 1;
      @(negedge clk);

      // table: word length and direction, sync loopback (R2 R3 R9 R13)
      for (int v = 0; v < 7; v++) begin
         wl = VEC[v][26:25];
         lb = VEC[v][24];
         d  = VEC[v][23:0];
         n  = wl_n(wl);
         stop_all();
         cfg_word_len = wl; cfg_lsb_first = lb; cfg_network = 0; cfg_frame_words = '0;
         cfg_sync = 1; cfg_fs_internal = 1; loop = 1;
         wr(d);
         check(!tx_empty, "R13 write fills", {31'd0, tx_empty}, 0);
         tx_en = 1; rx_en = 1;
         run_bits(n, s);
         check(s == exp_stream(d, n, lb), "R3 serial order", {8'd0, s}, {8'd0, exp_stream(d, n, lb)});
         check(tx_empty, "R13 load empties", {31'd0, tx_empty}, 1);
         tk(1, 0);
         check(rx_full && rx_rdata == exp_word(d, n), "R2 R9 received word",
               {8'd0, rx_rdata}, {8'd0, exp_word(d, n)});
         rd();
         check(!rx_full, "R13 read clears", {31'd0, rx_full}, 0);
      end

      // frame-sync lengths and frame size, async with both ticks (R6 R7 R8)
      stop_all();
      cfg_sync = 0; cfg_fs_internal = 1; cfg_word_len = 2'b00; cfg_frame_words = 5'd2;
      cfg_rx_fs_bit = 1; cfg_fs_differ = 1; loop = 0; sdi_drv = 0;
      tx_en = 1; rx_en = 1;
      cnt_tx = 0; cnt_rx = 0;
      for (int i = 0; i < 24; i++) begin
         tk(1, 1);
         cnt_tx += int'(fs_tx_out);
         cnt_rx += int'(fs_rx_out);
      end
      check(cnt_tx == 8, "R8 tx sync word-long when different", cnt_tx, 8);
      check(cnt_rx == 1, "R7 rx sync bit-long", cnt_rx, 1);
      cfg_fs_differ = 0;
      cnt_tx = 0;
      for (int i = 0; i < 24; i++) begin
         tk(1, 1);
         if (i == 0) check(fs_tx_out, "R6 frame of three slots restarts", {31'd0, fs_tx_out}, 1);
         cnt_tx += int'(fs_tx_out);
      end
      check(cnt_tx == 1, "R8 tx sync same length", cnt_tx, 1);
      cfg_frame_words = '0;
      cnt_tx = 0; cnt_rx = 0;
      for (int i = 0; i < 24; i++) begin
         tk(1, 1);
         cnt_tx += int'(fs_tx_out);
         cnt_rx += int'(fs_rx_out);
      end
      check(cnt_tx == 3 && cnt_rx == 3, "R6 zero field gives one-slot frames", cnt_tx * 16 + cnt_rx, 32'h33);
      cfg_rx_fs_bit = 0;
      cnt_rx = 0;
      for (int i = 0; i < 16; i++) begin
         tk(1, 1);
         cnt_rx += int'(fs_rx_out);
      end
      check(cnt_rx == 16, "R7 rx sync word-long", cnt_rx, 16);

      // normal mode skips later slots (R4)
      stop_all();
      rd();
      cfg_sync = 1; cfg_network = 0; cfg_frame_words = 5'd1; loop = 1; cfg_lsb_first = 0;
      wr(24'hA10000);
      tx_en = 1; rx_en = 1;
      run_bits(8, s);
      check(s == exp_stream(24'hA10000, 8, 0), "R4 slot 0 sends", {8'd0, s}, {8'd0, exp_stream(24'hA10000, 8, 0)});
      wr(24'hB20000);
      run_bits(8, s);
      check(s == 24'd0, "R4 slot 1 silent", {8'd0, s}, 0);
      check(!tx_empty, "R4 slot 1 does not consume", {31'd0, tx_empty}, 0);
      check(rx_full && rx_rdata == 24'hA10000, "R4 slot 0 received", {8'd0, rx_rdata}, 32'hA10000);
      tk(1, 0);
      check(tx_empty && !tx_underrun, "R4 next frame loads", {30'd0, tx_empty, tx_underrun}, 2);

      // network mode, then underrun and overrun together (R5 R11 R12)
      stop_all();
      rd();
      cfg_network = 1; cfg_frame_words = 5'd1;
      wr(24'h110000);
      tx_en = 1; rx_en = 1;
      tk(1, 0);
      wr(24'h220000);
      for (int i = 0; i < 7; i++) tk(1, 0);
      run_bits(8, s);
      check(s == exp_stream(24'h220000, 8, 0), "R5 slot 1 sends", {8'd0, s}, {8'd0, exp_stream(24'h220000, 8, 0)});
      check(tx_empty && !tx_underrun, "R5 slot 1 loaded", {30'd0, tx_empty, tx_underrun}, 2);
      check(rx_full && rx_rdata == 24'h110000, "R5 slot 0 received", {8'd0, rx_rdata}, 32'h110000);
      run_bits(8, s);
      check(s == exp_stream(24'h220000, 8, 0), "R11 previous data re-sent", {8'd0, s}, {8'd0, exp_stream(24'h220000, 8, 0)});
      check(tx_underrun, "R11 underrun set", {31'd0, tx_underrun}, 1);
      check(rx_overrun && rx_rdata == 24'h220000, "R12 overrun overwrites", {7'd0, rx_overrun, rx_rdata}, 32'h1220000);
      wr(24'h330000);
      check(!tx_underrun, "R11 write clears underrun", {31'd0, tx_underrun}, 0);
      rd();
      check(!rx_overrun && !rx_full, "R12 read clears overrun", {30'd0, rx_overrun, rx_full}, 0);

      // external frame sync, independent receiver (R9 R10)
      stop_all();
      cfg_sync = 0; cfg_fs_internal = 0; cfg_network = 0; cfg_frame_words = '0;
      cfg_word_len = 2'b00; cfg_lsb_first = 0; loop = 0; sdi_drv = 1; fs_rx_in = 0;
      rx_en = 1;
      for (int i = 0; i < 12; i++) tk(0, 1);
      check(!rx_full, "R10 nothing before sync", {31'd0, rx_full}, 0);
      fs_rx_in = 1;
      for (int i = 0; i < 3; i++) tk(1, 0);
      check(!rx_full, "R9 receiver ignores tx_tick when async", {31'd0, rx_full}, 0);
      tk(0, 1);
      fs_rx_in = 0;
      d = 24'h6B0000;
      for (int i = 0; i < 8; i++) begin
         sdi_drv = d[23 - i];
         tk(0, 1);
      end
      check(rx_full && rx_rdata == 24'h6B0000, "R10 external sync frames word", {8'd0, rx_rdata}, 32'h6B0000);
      rd();

      // disabled engine stays quiet (R14)
      stop_all();
      cfg_fs_internal = 1; cfg_sync = 1; loop = 1;
      wr(24'h777777);
      quiet = 1;
      for (int i = 0; i < 10; i++) begin
         tk(1, 1);
         if (fs_tx_out || fs_rx_out || sdo) quiet = 0;
      end
      check(quiet, "R14 no sync or data while disabled", {31'd0, quiet}, 1);
      check(!tx_empty, "R14 written word kept", {31'd0, tx_empty}, 0);

      finish_run();
   end

endmodule